// File: doc/BRIEF.md
# PHY Vendor Control Port Bridge

This block sits between a processor register port and the vendor-specific control pins of a UTMI PHY. Software writes one 32-bit register that names a PHY port, a 4-bit control nibble and an active-low "start" flag. When the start flag is 0, the write launches a short hardware sequence. The sequence presents the nibble and port select to the PHY for one setup cycle, then pulls an active-low load strobe low for a programmable number of clocks. It then waits a programmable settle time and captures the PHY's 8-bit vendor status byte into the low byte of the register.

A busy bit stays set for the whole sequence. Software polls this bit before issuing the next operation, and the block discards any write that arrives while it is set. A write whose start flag is 1 only updates the stored fields; it starts no sequence.

The sequencer is a four-state machine. The states are IDLE, SETUP, STROBE and SETTLE. IDLE goes to SETUP on an accepted write with bit 12 = 0. SETUP goes to STROBE after exactly one cycle. STROBE goes to SETTLE when its cycle count expires. SETTLE goes back to IDLE when its cycle count expires, and the status capture happens on that same edge.

Top module: `phy_vctl_bridge`

## Requirements
- R1: After reset the register reads 0x0000_1000 (fields 0, start flag 1, busy 0), the load strobe is high, and the port and control outputs are 0.
- R2: Bits 31:18 always read 0. Write data in bits 17 and 7:0 never changes what those bits read.
- R3: A write accepted in IDLE stores bits 16:13 as the port select and bits 11:8 as the control nibble. If bit 12 is 0, busy (bit 17) reads 1 from the next cycle.
- R4: A write accepted in IDLE with bit 12 = 1 stores bit 12 and the fields. It issues no strobe, and busy stays 0.
- R5: The cycle after a starting write is SETUP. In SETUP the port and control outputs carry the stored fields and the load strobe is high.
- R6: After SETUP the load strobe is low for exactly STROBE_CYCLES cycles, with port and control held at the stored fields.
- R7: After the strobe rises, SETTLE lasts SAMPLE_DELAY cycles. On the edge that ends SETTLE, busy clears and the PHY status byte is captured into bits 7:0. Busy therefore reads 1 for 1+STROBE_CYCLES+SAMPLE_DELAY cycles.
- R8: A write that arrives while busy reads 1 is discarded. No field changes and no second sequence starts.
- R9: While busy is 0, the port and control outputs are 0 and the load strobe is high.
- R10: Bits 7:0 change only at the end of a sequence and otherwise hold the last captured value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write enable, one cycle per write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read value |
| phy_port_sel | output | 4 | Port select presented to the PHY |
| phy_ctrl | output | 4 | Control nibble presented to the PHY |
| phy_load_n | output | 1 | Active-low load strobe to the PHY |
| phy_status | input | 8 | Vendor status byte from the PHY |

## Verification
A sequencer stuck in, or skipping, one of its states shows up at the ports within one cycle. The busy bit, the strobe level or the driven port/control value then disagrees with the cycle-exact reference model on the very next clock. A wrong cycle count in STROBE or SETTLE moves the strobe rising edge or the busy falling edge by at least one cycle. A capture on the wrong edge, or from the wrong source, leaves a wrong status byte that stays visible until the next sequence ends. A write accepted while busy changes the read-back fields or the strobe timing on the cycle after the write.

// File: rtl/phy_vctl_pkg.sv
package phy_vctl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2,
        ST_SETTLE = 2'd3
    } vctl_state_e;

    localparam int BIT_BUSY     = 17;
    localparam int BIT_PORT_LO  = 13;
    localparam int BIT_START_N  = 12;
    localparam int BIT_CTRL_LO  = 8;
    localparam int BIT_STAT_LO  = 0;

endpackage

// File: rtl/vctl_timer.sv
module vctl_timer #(
    parameter int MAX_COUNT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic [$clog2(MAX_COUNT+1)-1:0] load_val,
    output logic expired
);
    localparam int CW = $clog2(MAX_COUNT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/vctl_seq_fsm.sv
module vctl_seq_fsm
    import phy_vctl_pkg::*;
#(
    parameter int STROBE_CYCLES = 2,
    parameter int SAMPLE_DELAY  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic drive,
    output logic load_n,
    output logic capture
);
    localparam int MAXC = (STROBE_CYCLES > SAMPLE_DELAY) ? STROBE_CYCLES : SAMPLE_DELAY;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] STROBE_RELOAD = CW'(STROBE_CYCLES - 1);
    localparam logic [CW-1:0] SETTLE_RELOAD = CW'(SAMPLE_DELAY - 1);

    vctl_state_e state_q, state_d;
    logic        tmr_load;
    logic [CW-1:0] tmr_val;
    logic        tmr_expired;

    vctl_timer #(.MAX_COUNT(MAXC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    // next-state and timer control
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_SETUP;
            end
            ST_SETUP: begin
                state_d  = ST_STROBE;
                tmr_load = 1'b1;
                tmr_val  = STROBE_RELOAD;
            end
            ST_STROBE: begin
                if (tmr_expired) begin
                    state_d  = ST_SETTLE;
                    tmr_load = 1'b1;
                    tmr_val  = SETTLE_RELOAD;
                end
            end
            ST_SETTLE: begin
                if (tmr_expired) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        busy    = 1'b0;
        drive   = 1'b0;
        load_n  = 1'b1;
        capture = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SETUP: begin
                busy  = 1'b1;
                drive = 1'b1;
            end
            ST_STROBE: begin
                busy   = 1'b1;
                drive  = 1'b1;
                load_n = 1'b0;
            end
            ST_SETTLE: begin
                busy    = 1'b1;
                drive   = 1'b1;
                capture = tmr_expired;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/vctl_regfile.sv
module vctl_regfile #(
    parameter int PORT_W = 4,
    parameter int CTRL_W = 4,
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PORT_W-1:0] wr_port,
    input  logic              wr_start_n,
    input  logic [CTRL_W-1:0] wr_ctrl,
    input  logic              capture,
    input  logic [STAT_W-1:0] status_in,
    output logic [PORT_W-1:0] port_q,
    output logic              start_n_q,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [STAT_W-1:0] stat_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_q    <= '0;
            start_n_q <= 1'b1;
            ctrl_q    <= '0;
        end else if (wr_en) begin
            port_q    <= wr_port;
            start_n_q <= wr_start_n;
            ctrl_q    <= wr_ctrl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       stat_q <= '0;
        else if (capture) stat_q <= status_in;
    end

endmodule

// File: rtl/phy_vctl_bridge.sv
module phy_vctl_bridge
    import phy_vctl_pkg::*;
#(
    parameter int STROBE_CYCLES = 2,
    parameter int SAMPLE_DELAY  = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic [3:0]  phy_port_sel,
    output logic [3:0]  phy_ctrl,
    output logic        phy_load_n,
    input  logic [7:0]  phy_status
);
    localparam int PORT_W = 4;
    localparam int CTRL_W = 4;
    localparam int STAT_W = 8;

    logic              busy, drive, load_n, capture;
    logic              wr_accept, start;
    logic [PORT_W-1:0] port_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic [STAT_W-1:0] stat_q;
    logic              start_n_q;

    assign wr_accept = reg_wr && !busy;
    assign start     = wr_accept && !reg_wdata[BIT_START_N];

    vctl_seq_fsm #(
        .STROBE_CYCLES (STROBE_CYCLES),
        .SAMPLE_DELAY  (SAMPLE_DELAY)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .busy    (busy),
        .drive   (drive),
        .load_n  (load_n),
        .capture (capture)
    );

    vctl_regfile #(
        .PORT_W (PORT_W),
        .CTRL_W (CTRL_W),
        .STAT_W (STAT_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_accept),
        .wr_port    (reg_wdata[BIT_PORT_LO +: PORT_W]),
        .wr_start_n (reg_wdata[BIT_START_N]),
        .wr_ctrl    (reg_wdata[BIT_CTRL_LO +: CTRL_W]),
        .capture    (capture),
        .status_in  (phy_status),
        .port_q     (port_q),
        .start_n_q  (start_n_q),
        .ctrl_q     (ctrl_q),
        .stat_q     (stat_q)
    );

    always_comb begin
        reg_rdata                          = '0;
        reg_rdata[BIT_BUSY]                = busy;
        reg_rdata[BIT_PORT_LO +: PORT_W]   = port_q;
        reg_rdata[BIT_START_N]             = start_n_q;
        reg_rdata[BIT_CTRL_LO +: CTRL_W]   = ctrl_q;
        reg_rdata[BIT_STAT_LO +: STAT_W]   = stat_q;
    end

    assign phy_port_sel = drive ? port_q : '0;
    assign phy_ctrl     = drive ? ctrl_q : '0;
    assign phy_load_n   = load_n;

endmodule

// File: rtl/phy_vctl_bridge_chk.sv
module phy_vctl_bridge_chk #(
    parameter int STROBE_CYCLES = 2,
    parameter int SAMPLE_DELAY  = 2
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic [3:0]  phy_port_sel,
    input logic [3:0]  phy_ctrl,
    input logic        phy_load_n
);
    logic [15:0] lo_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           lo_cnt <= '0;
        else if (!phy_load_n) lo_cnt <= (lo_cnt == 16'hFFFF) ? lo_cnt : lo_cnt + 1'b1;
        else                  lo_cnt <= '0;
    end

    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[31:18] == '0);

    p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_wdata[12] && !reg_rdata[17]) |=> reg_rdata[17]);

    p_nop_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[12] && !reg_rdata[17]) |=> !reg_rdata[17]);

    p_strobe_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phy_load_n) |-> (lo_cnt == 16'(STROBE_CYCLES)));

    p_strobe_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !phy_load_n |-> reg_rdata[17]);

    p_busy_write_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_rdata[17]) |=> $stable(reg_rdata[16:8]));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[17] |-> (phy_load_n && phy_port_sel == '0 && phy_ctrl == '0));

    p_status_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[17] |=> $stable(reg_rdata[7:0]));

endmodule

bind phy_vctl_bridge phy_vctl_bridge_chk #(
    .STROBE_CYCLES (STROBE_CYCLES),
    .SAMPLE_DELAY  (SAMPLE_DELAY)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .phy_port_sel (phy_port_sel),
    .phy_ctrl     (phy_ctrl),
    .phy_load_n   (phy_load_n)
);

// File: tb/phy_vctl_bridge_bench.sv
`timescale 1ns/1ps
module phy_vctl_bridge_bench;
    localparam int S = 2;
    localparam int D = 2;
    localparam int SEQ_LEN = 1 + S + D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  phy_port_sel, phy_ctrl;
    logic        phy_load_n;
    logic [7:0]  phy_status;
    logic [7:0]  phy_lat = '0;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    always #2 clk = ~clk;

    phy_vctl_bridge #(.STROBE_CYCLES(S), .SAMPLE_DELAY(D)) u_phy_vctl_bridge (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .phy_port_sel(phy_port_sel), .phy_ctrl(phy_ctrl),
        .phy_load_n(phy_load_n), .phy_status(phy_status)
    );

    // PHY model: latches port/control while the strobe is low
    always @(posedge clk) if (!phy_load_n) phy_lat <= {phy_port_sel, phy_ctrl};
    assign phy_status = phy_lat ^ 8'h5A;

    // reference model
    int m_port, m_startn, m_ctrl, m_stat, m_busy, m_left;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_port = 0; m_startn = 1; m_ctrl = 0; m_stat = 0; m_busy = 0; m_left = 0;
        end else if (m_busy != 0) begin
            m_left = m_left - 1;
            if (m_left == 0) begin
                m_busy = 0;
                m_stat = ((m_port << 4) | m_ctrl) ^ 8'h5A;
            end
        end else if (reg_wr) begin
            m_port   = int'(reg_wdata[16:13]);
            m_startn = int'(reg_wdata[12]);
            m_ctrl   = int'(reg_wdata[11:8]);
            if (m_startn == 0) begin
                m_busy = 1;
                m_left = SEQ_LEN;
            end
        end
    end

    task automatic cmp(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int phase, e_ld, e_drv;
            int e_rd;
            phase = SEQ_LEN - m_left;
            e_ld  = (m_busy != 0 && phase >= 1 && phase <= S) ? 0 : 1;
            e_drv = m_busy;
            e_rd  = (m_busy << 17) | (m_port << 13) | (m_startn << 12) | (m_ctrl << 8) | m_stat;
            cmp("R3/R7/R8/R10", "reg_rdata", int'(reg_rdata), e_rd);
            cmp("R5/R6", "phy_load_n", int'(phy_load_n), e_ld);
            cmp("R5/R9", "phy_port_sel", int'(phy_port_sel), e_drv ? m_port : 0);
            cmp("R6/R9", "phy_ctrl", int'(phy_ctrl), e_drv ? m_ctrl : 0);
        end
    end

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    function automatic logic [31:0] mk(input int port, input int nop, input int ctrl);
        return (32'(port) << 13) | (32'(nop) << 12) | (32'(ctrl) << 8);
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin : watchdog
        #100000;
        if (!done) begin
            errors++;
            vectors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        // R1: reset values
        vectors++;
        if (reg_rdata !== 32'h0000_1000 || phy_load_n !== 1'b1 || phy_port_sel !== 4'h0 || phy_ctrl !== 4'h0) begin
            errors++;
            $display("FAIL R1 reset actual=%h expected=%h", reg_rdata, 32'h0000_1000);
        end
        @(negedge clk) rst_n = 1'b1;
        idle(2);
        // R4: no-op write stores fields only
        wr(mk(5, 1, 9));
        idle(4);
        // R3/R5/R6/R7: load sequence
        wr(mk(3, 0, 12));
        idle(8);
        // R2: read-only and reserved bits set in write data
        wr(32'hFFFC_0000 | 32'h0002_00FF | mk(10, 0, 6));
        idle(8);
        // R8: writes during busy are discarded
        wr(mk(1, 0, 2));
        wr(mk(15, 0, 15));
        wr(mk(7, 1, 4));
        idle(8);
        // back-to-back start right after busy clears, R10 hold across a no-op
        wr(mk(0, 0, 0));
        idle(SEQ_LEN - 1);
        wr(mk(15, 0, 15));
        idle(8);
        wr(mk(2, 1, 3));
        idle(5);
        // mid-run reset returns to R1 state
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        vectors++;
        if (reg_rdata !== 32'h0000_1000) begin
            errors++;
            $display("FAIL R1 reset actual=%h expected=%h", reg_rdata, 32'h0000_1000);
        end
        @(negedge clk) rst_n = 1'b1;
        wr(mk(9, 0, 1));
        idle(8);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule